// File: doc/BRIEF.md
# Skewed Matrix Row/Column Access Unit

This block keeps a square matrix of LANES by LANES words spread across LANES independent single-port-read memory banks. Each bank has LANES words. The layout is chosen so that every matrix row and every matrix column touches each bank exactly once. Because of this, a whole row or a whole column can be fetched in one access, with all banks read together. A single uniform rotation of the bank outputs then puts the words in lane order. LANES must be a power of two, and all index arithmetic wraps naturally at log2(LANES) bits.

Element (i,j) lives in bank (i+j) mod LANES, at word i. The write port stores one element, addressed by row and column. A read request names either a row or a column and gives its index. Two cycles later the block presents all LANES elements on one wide output, with a valid flag:
- For a row read, lane j holds column j.
- For a column read, lane i holds row i.

A new read and a new write may be issued on every cycle.

Top module: `skew_store`

## Requirements
- R1: While reset is high and on the first cycle after it, rd_valid is 0 and rd_data is all zeros.
- R2: A row read (rd_col=0) of index r returns, in lane j (bits [j*DW +: DW]), the element last written at row r, column j, for every j.
- R3: A column read (rd_col=1) of index c returns, in lane i (bits [i*DW +: DW]), the element last written at row i, column c, for every i.
- R4: rd_valid is 1 exactly on the cycle two clock edges after an accepted rd_req, and on no other cycle.
- R5: Read requests issued on consecutive cycles, mixing rows and columns, are all answered, one per cycle, in issue order.
- R6: A read issued on the same cycle as a write to one of the words it covers returns the old value. The following read returns the new value.
- R7: While rd_valid is 0, rd_data keeps the value of the last valid result.
- R8: A write to one element changes only that element. Every other lane of a later row or column read keeps its prior value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one element this cycle |
| wr_row | input | log2(LANES) | Row index of the written element |
| wr_col | input | log2(LANES) | Column index of the written element |
| wr_data | input | DW | Element value to write |
| rd_req | input | 1 | Start a row or column read |
| rd_col | input | 1 | 0 selects a row, 1 selects a column |
| rd_idx | input | log2(LANES) | Row or column index to read |
| rd_valid | output | 1 | rd_data carries a new result |
| rd_data | output | LANES*DW | Result, lane m in bits [m*DW +: DW] |

## Verification
On every cycle, the bound checker checks the timing behaviour:
- The two-cycle request-to-valid relation, in both directions.
- The idle state that follows reset.
- That the output holds between results.

Which data arrives in each lane cannot be expressed without a model of the whole matrix, so only the bench's scenarios show it. Those scenarios cover:
- Full fills with two distinct patterns.
- Sweeps over every row and every column, issued back to back.
- Same-cycle write and read collisions.
- Isolated single-element updates.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef enum logic {
    SEL_ROW = 1'b0,
    SEL_COL = 1'b1
  } sel_e;
endpackage

// File: rtl/skew_bank.sv
module skew_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read-first: a same-cycle write is not seen by this read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/skew_addr_gen.sv
module skew_addr_gen
  import skew_pkg::*;
#(
  parameter int LANES = 8,
  parameter int BANK  = 0,
  parameter int AW    = $clog2(LANES)
) (
  input  sel_e          sel,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] BANK_ID = AW'(BANK);

  // a row uses the same word in every bank; a column needs word (bank - idx)
  always_comb begin
    if (sel == SEL_COL) addr = BANK_ID - idx;
    else                addr = idx;
  end
endmodule

// File: rtl/skew_rotator.sv
module skew_rotator #(
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int AW    = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] bank_q,
  input  logic [AW-1:0]       amt,
  output logic [LANES*DW-1:0] lanes
);
  logic [DW-1:0] src_arr [LANES];

  for (genvar b = 0; b < LANES; b++) begin : g_unpack
    assign src_arr[b] = bank_q[b*DW +: DW];
  end

  // lane m takes bank (m + amt) mod LANES, for rows and columns alike
  for (genvar m = 0; m < LANES; m++) begin : g_lane
    localparam logic [AW-1:0] LANE_ID = AW'(m);
    logic [AW-1:0] src;
    assign src                = LANE_ID + amt;
    assign lanes[m*DW +: DW]  = src_arr[src];
  end
endmodule

// File: rtl/skew_store.sv
module skew_store
  import skew_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int AW    = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_row,
  input  logic [AW-1:0]       wr_col,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_req,
  input  logic                rd_col,
  input  logic [AW-1:0]       rd_idx,
  output logic                rd_valid,
  output logic [LANES*DW-1:0] rd_data
);
  localparam int VW = LANES * DW;

  sel_e          sel;
  logic [AW-1:0] wr_bank;
  logic [VW-1:0] bank_q;
  logic [VW-1:0] aligned;
  logic          s1_valid;
  logic [AW-1:0] s1_idx;

  assign sel     = rd_col ? SEL_COL : SEL_ROW;
  assign wr_bank = wr_row + wr_col;

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    localparam logic [AW-1:0] K_ID = AW'(k);
    logic [AW-1:0] raddr;
    logic          we_k;

    assign we_k = wr_en && (wr_bank == K_ID);

    skew_addr_gen #(.LANES(LANES), .BANK(k), .AW(AW)) u_addr (
      .sel  (sel),
      .idx  (rd_idx),
      .addr (raddr)
    );

    skew_bank #(.DW(DW), .DEPTH(LANES), .AW(AW)) u_bank (
      .clk   (clk),
      .we    (we_k),
      .waddr (wr_row),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (bank_q[k*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= rd_req;
      s1_idx   <= rd_idx;
    end
  end

  skew_rotator #(.LANES(LANES), .DW(DW), .AW(AW)) u_rot (
    .bank_q (bank_q),
    .amt    (s1_idx),
    .lanes  (aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= s1_valid;
      if (s1_valid) rd_data <= aligned;
    end
  end
endmodule

// File: rtl/skew_store_chk.sv
module skew_store_chk #(
  parameter int LANES = 8,
  parameter int DW    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_req,
  input logic                rd_valid,
  input logic [LANES*DW-1:0] rd_data
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!rd_valid && rd_data == '0)); // R1

  AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(rd_req, 2)) |-> rd_valid); // R4

  AST_VALID_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && rd_valid) |-> $past(rd_req, 2)); // R4

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1 && !rd_valid) |-> $stable(rd_data)); // R7
endmodule

bind skew_store skew_store_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/skew_store_test.sv
module skew_store_test;
  localparam int P  = 8;
  localparam int DW = 16;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst, wr_en, rd_req, rd_col, rd_valid;
  logic [AW-1:0]   wr_row, wr_col, rd_idx;
  logic [DW-1:0]   wr_data;
  logic [P*DW-1:0] rd_data;

  skew_store #(.LANES(P), .DW(DW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .rd_req(rd_req), .rd_col(rd_col), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int total = 0;
  int bad   = 0;
  logic [DW-1:0]   model [P][P];
  logic            pv    [2];
  logic [P*DW-1:0] pexp  [2];
  string           ptag  [2];
  logic [P*DW-1:0] last_exp;

  function automatic logic [P*DW-1:0] expect_vec(input logic col, input logic [AW-1:0] idx);
    logic [P*DW-1:0] v;
    for (int m = 0; m < P; m++)
      v[m*DW +: DW] = col ? model[m][idx] : model[idx][m];
    return v;
  endfunction

  function automatic logic [DW-1:0] pat(input int salt, input int i, input int j);
    return {4'(salt), 4'(i), 4'(j), 4'hA};
  endfunction

  // One cycle: check what the pipeline promises now, then drive the next inputs.
  task automatic step(input logic rq, input logic col, input logic [AW-1:0] idx,
                      input logic wr, input logic [AW-1:0] wi, input logic [AW-1:0] wj,
                      input logic [DW-1:0] wd, input string tag);
    @(negedge clk);
    total++;
    if (rd_valid !== pv[1]) begin
      bad++;
      $display("FAIL R4: rd_valid=%b expected=%b", rd_valid, pv[1]);
    end
    total++;
    if (pv[1]) begin
      if (rd_data !== pexp[1]) begin
        bad++;
        $display("FAIL %s: rd_data=%h expected=%h", ptag[1], rd_data, pexp[1]);
      end
      last_exp = pexp[1];
    end else if (rd_data !== last_exp) begin
      bad++;
      $display("FAIL R7: rd_data=%h expected=%h", rd_data, last_exp);
    end
    pv[1] = pv[0]; pexp[1] = pexp[0]; ptag[1] = ptag[0];
    pv[0] = rq;    ptag[0] = tag;
    if (rq) pexp[0] = expect_vec(col, idx);
    rd_req = rq; rd_col = col; rd_idx = idx;
    wr_en = wr; wr_row = wi; wr_col = wj; wr_data = wd;
    if (wr) model[wi][wj] = wd;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, '0, 0, '0, '0, '0, "R7");
  endtask

  task automatic fill(input int salt);
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        step(0, 0, '0, 1, AW'(i), AW'(j), pat(salt, i, j), "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 0; rd_req = 0; rd_col = 0; rd_idx = '0;
    wr_row = '0; wr_col = '0; wr_data = '0;
    pv[0] = 0; pv[1] = 0; pexp[0] = '0; pexp[1] = '0;
    ptag[0] = ""; ptag[1] = ""; last_exp = '0;
    repeat (3) @(negedge clk);
    total++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      bad++;
      $display("FAIL R1: rd_valid=%b rd_data=%h expected=0/0", rd_valid, rd_data);
    end
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      bad++;
      $display("FAIL R1: rd_valid=%b rd_data=%h expected=0/0", rd_valid, rd_data);
    end

    fill(1);
    for (int r = 0; r < P; r++) step(1, 0, AW'(r), 0, '0, '0, '0, "R2");
    for (int c = 0; c < P; c++) step(1, 1, AW'(c), 0, '0, '0, '0, "R3");
    idle(4);

    // collision: write (3,5) while reading row 3, then read row 3 and column 5
    step(1, 0, 3'd3, 1, 3'd3, 3'd5, 16'hBEEF, "R6");
    step(1, 0, 3'd3, 0, '0, '0, '0, "R6");
    step(1, 1, 3'd5, 0, '0, '0, '0, "R6");
    // column collision on (7,2), which lives in bank 1
    step(1, 1, 3'd2, 1, 3'd7, 3'd2, 16'h1234, "R6");
    step(1, 1, 3'd2, 0, '0, '0, '0, "R6");
    idle(3);

    // isolated update touches one element only
    step(0, 0, '0, 1, 3'd6, 3'd1, 16'h5A5A, "R8");
    step(1, 1, 3'd1, 0, '0, '0, '0, "R8");
    step(1, 0, 3'd6, 0, '0, '0, '0, "R8");
    step(1, 0, 3'd7, 0, '0, '0, '0, "R8");
    idle(3);

    fill(2);
    for (int k = 0; k < P; k++) begin
      step(1, 0, AW'(k), 0, '0, '0, '0, "R5");
      step(1, 1, AW'(P - 1 - k), 0, '0, '0, '0, "R5");
    end
    idle(5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule